// File: doc/BRIEF.md
# Registered command buffer with parity

This block sits on the address/command path between a memory controller and a bank of memory devices. On every rising clock edge it captures a 28-bit command word and drives it out on two identical registered copies, so one input load becomes two output nets. It also checks the word against a parity bit from the controller. That parity bit arrives one clock after the word it protects. A mismatch pulls an active-low error flag low and holds it there for a minimum time.

Two pairs of active-low chip selects decide whether a captured word takes part in the parity check. If every chip select is high and the gate-enable input is also high, the block enters a low-power hold: the outputs freeze and the error flag keeps its state until checking resumes. The word path has no handshake. The block takes a new word on every edge it is not holding, and it cannot apply back-pressure. An active-low reset acts without the clock and returns the block to its idle state.

Top module: `cmdbuf_reg_par`

## Requirements
- R1: While `rst_n` is low, `qa` and `qb` read all zeros and `err_n` reads 1. This takes effect at once, without waiting for a clock edge.
- R2: At a rising edge outside low-power hold, `qa` and `qb` take the value of `din` sampled at that edge.
- R3: `qa` and `qb` are equal in every cycle.
- R4: Low-power hold means all four chip-select bits (`cs_a` and `cs_b`) are 1 and `gate_en` is 1. At an edge where this holds, `qa` and `qb` do not change.
- R5: When `gate_en` is 0, the outputs update at every edge, even if all chip selects are 1.
- R6: A word is checked when, at its capture edge, at least one bit of `cs_a` or at least one bit of `cs_b` is 0. At the next edge the block XORs `din[21:0]` of that word with `par_in` sampled at that next edge. A result of 1 is an error, and `err_n` is 0 after that edge.
- R7: `din[27:22]` takes no part in the parity check.
- R8: After an error edge with no further error, `err_n` stays 0 for exactly two cycles while checking continues. It then returns to 1 at the next checked edge with matching parity. A new error during the hold restarts the two cycles.
- R9: At an edge whose preceding capture edge had both bits of `cs_a` and both bits of `cs_b` at 1, no check takes place. Both `err_n` and the hold time keep their values, whatever the value of `par_in`.
- R10: If `err_n` is 0 when low-power hold begins, it stays 0 through the whole hold and for two checked cycles after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 28 | Command word |
| par_in | input | 1 | Parity bit for the word captured one edge earlier |
| cs_a | input | 2 | First chip-select pair, active low |
| cs_b | input | 2 | Second chip-select pair, active low |
| gate_en | input | 1 | Allows low-power hold when all selects are high |
| qa | output | 28 | First registered copy of the word |
| qb | output | 28 | Second registered copy of the word |
| err_n | output | 1 | Parity error flag, active low |

## Verification
Several properties are checked on every clock edge:
- the two copies match;
- outputs follow the previous word outside low-power hold and stay stable inside it;
- the flag stays still when no check is due;
- every falling edge of the flag traces back to a parity mismatch, and lasts at least two cycles.

Some behaviour needs a scenario rather than a single-cycle property:
- the exact release cycle after the hold;
- the restart of the hold on back-to-back errors;
- the stretch across a low-power interval;
- the exclusion of the top six bits from parity;
- the immediate effect of reset in mid-cycle.

The bench covers these with a table of vectors, directed steps and a randomised comparison against a reference model.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;

  localparam int unsigned CB_DATA_W   = 28;
  localparam int unsigned CB_PAR_W    = 22;
  localparam int unsigned CB_HOLD_CYC = 2;

  typedef enum logic {
    FLAG_ERR = 1'b0,
    FLAG_OK  = 1'b1
  } flag_t;

  // width of a down-counter that must hold values up to n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cmdbuf_cs_decode.sv
`timescale 1ns/1ps
module cmdbuf_cs_decode #(
  parameter int unsigned NUM_PAIRS = 2
) (
  input  logic [2*NUM_PAIRS-1:0] cs,
  input  logic                   gate_en,
  output logic                   eval_en,
  output logic                   lpm
);

  logic [NUM_PAIRS-1:0] pair_act;

  // a pair is active when any of its two selects is low
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_act[p] = ~&cs[2*p +: 2];
  end

  assign eval_en = |pair_act;
  assign lpm     = gate_en & ~eval_en;

endmodule

// File: rtl/cmdbuf_out_reg.sv
`timescale 1ns/1ps
module cmdbuf_out_reg #(
  parameter int unsigned DATA_W = 28,
  parameter int unsigned COPIES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cap_en,
  input  logic [DATA_W-1:0]              d,
  output logic [COPIES-1:0][DATA_W-1:0]  q
);

  // one physical register per copy, all loaded on the same edge
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[c] <= '0;
      end else if (cap_en) begin
        q[c] <= d;
      end
    end
  end

endmodule

// File: rtl/cmdbuf_parity_chk.sv
`timescale 1ns/1ps
module cmdbuf_parity_chk
  import cmdbuf_pkg::*;
#(
  parameter int unsigned PAR_W    = 22,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_en,
  input  logic [PAR_W-1:0] d,
  input  logic             par_in,
  output logic             err_n
);

  localparam int unsigned      CNT_W  = cnt_width(HOLD_CYC);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

  logic             eval_q;
  logic             par_q;
  logic [CNT_W-1:0] hold_q;
  flag_t            flag_q;
  logic             mismatch;

  // stage 1: reduce the covered bits to one bit and remember if it counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      eval_q <= eval_en;
      par_q  <= ^d;
    end
  end

  assign mismatch = eval_q & (par_q ^ par_in);

  // stage 2: compare with the late parity bit, stretch the error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FLAG_OK;
      hold_q <= '0;
    end else if (eval_q) begin
      if (par_q ^ par_in) begin
        flag_q <= FLAG_ERR;
        hold_q <= RELOAD;
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else begin
        flag_q <= FLAG_OK;
      end
    end
  end

  assign err_n = (flag_q == FLAG_OK);

  AST_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_q |=> $stable(err_n)); // R9

  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(mismatch)); // R6

  AST_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> $past(eval_q && !mismatch)); // R8

  if (HOLD_CYC > 1) begin : g_min_low
    AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_n) |=> !err_n); // R8
  end

endmodule

// File: rtl/cmdbuf_reg_par.sv
`timescale 1ns/1ps
module cmdbuf_reg_par
  import cmdbuf_pkg::*;
#(
  parameter int unsigned DATA_W   = CB_DATA_W,
  parameter int unsigned PAR_W    = CB_PAR_W,
  parameter int unsigned HOLD_CYC = CB_HOLD_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              par_in,
  input  logic [1:0]        cs_a,
  input  logic [1:0]        cs_b,
  input  logic              gate_en,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb,
  output logic              err_n
);

  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned COPIES    = 2;

  logic                          eval_en;
  logic                          lpm;
  logic [COPIES-1:0][DATA_W-1:0] q_copy;

  cmdbuf_cs_decode #(
    .NUM_PAIRS (NUM_PAIRS)
  ) i_cs_decode (
    .cs      ({cs_b, cs_a}),
    .gate_en (gate_en),
    .eval_en (eval_en),
    .lpm     (lpm)
  );

  cmdbuf_out_reg #(
    .DATA_W (DATA_W),
    .COPIES (COPIES)
  ) i_out_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (!lpm),
    .d      (din),
    .q      (q_copy)
  );

  cmdbuf_parity_chk #(
    .PAR_W    (PAR_W),
    .HOLD_CYC (HOLD_CYC)
  ) i_parity_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval_en (eval_en),
    .d       (din[PAR_W-1:0]),
    .par_in  (par_in),
    .err_n   (err_n)
  );

  assign qa = q_copy[0];
  assign qb = q_copy[1];

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    qa == qb); // R3

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !lpm |=> qa == $past(din)); // R2

  AST_LPM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lpm |=> $stable(qa)); // R4

endmodule

// File: tb/test_cmdbuf_reg_par.sv
`timescale 1ns/1ps
module test_cmdbuf_reg_par;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] din = '0;
  logic        par_in = 1'b0;
  logic [1:0]  cs_a = 2'b11;
  logic [1:0]  cs_b = 2'b11;
  logic        gate_en = 1'b0;
  logic [27:0] qa, qb;
  logic        err_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmdbuf_reg_par i_cmdbuf_reg_par (
    .clk(clk), .rst_n(rst_n), .din(din), .par_in(par_in),
    .cs_a(cs_a), .cs_b(cs_b), .gate_en(gate_en),
    .qa(qa), .qb(qb), .err_n(err_n)
  );

  // fields: cs_a, cs_b, gate_en, par_in, din, expected q, expected err_n
  localparam logic [62:0] VEC [16] = '{
    {2'b10, 2'b11, 1'b0, 1'b0, 28'h0000001, 28'h0000001, 1'b1},
    {2'b10, 2'b11, 1'b0, 1'b1, 28'h0000003, 28'h0000003, 1'b1},
    {2'b10, 2'b11, 1'b0, 1'b1, 28'h0400000, 28'h0400000, 1'b0},
    {2'b10, 2'b11, 1'b0, 1'b0, 28'h0000007, 28'h0000007, 1'b0},
    {2'b10, 2'b11, 1'b0, 1'b1, 28'hFC00000, 28'hFC00000, 1'b1},
    {2'b11, 2'b01, 1'b0, 1'b0, 28'h0000005, 28'h0000005, 1'b1},
    {2'b11, 2'b11, 1'b0, 1'b1, 28'h000000F, 28'h000000F, 1'b0},
    {2'b11, 2'b11, 1'b1, 1'b0, 28'h1234567, 28'h000000F, 1'b0},
    {2'b11, 2'b11, 1'b1, 1'b1, 28'h7654321, 28'h000000F, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b1, 28'h0000001, 28'h0000001, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b1, 28'h0000000, 28'h0000000, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b0, 28'h03FFFFF, 28'h03FFFFF, 1'b1},
    {2'b00, 2'b11, 1'b1, 1'b1, 28'h0000000, 28'h0000000, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b1, 28'h0000001, 28'h0000001, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b1, 28'h0000000, 28'h0000000, 1'b0},
    {2'b00, 2'b11, 1'b1, 1'b0, 28'h0000000, 28'h0000000, 1'b1}
  };

  // reference model state
  logic [27:0] m_q;
  logic        m_eval, m_p1, m_err;
  int          m_cnt;

  task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic lpm_now, eval_now;
    eval_now = (cs_a != 2'b11) || (cs_b != 2'b11);
    lpm_now  = gate_en && !eval_now;
    if (m_eval) begin
      if (m_p1 ^ par_in) begin
        m_err = 1'b0;
        m_cnt = 1;
      end else if (m_cnt != 0) begin
        m_cnt--;
      end else begin
        m_err = 1'b1;
      end
    end
    m_eval = eval_now;
    m_p1   = ^din[21:0];
    if (!lpm_now) m_q = din;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset qa", qa, 28'h0);
    check("R1 reset qb", qb, 28'h0);
    check("R1 reset err_n", {27'h0, err_n}, 28'h1);
    rst_n = 1'b1;

    // vector table: capture, copies, hold, parity timing, stretch across low power
    for (int i = 0; i < 16; i++) begin
      cs_a    = VEC[i][62:61];
      cs_b    = VEC[i][60:59];
      gate_en = VEC[i][58];
      par_in  = VEC[i][57];
      din     = VEC[i][56:29];
      @(posedge clk);
      #1;
      check($sformatf("R2 R4 R5 R7 table row %0d q", i), qa, VEC[i][28:1]);
      check($sformatf("R3 table row %0d copy", i), qb, qa);
      check($sformatf("R6 R8 R9 R10 table row %0d err_n", i), {27'h0, err_n}, {27'h0, VEC[i][0]});
    end

    // provoke an error, then reset asynchronously in mid-cycle
    cs_a = 2'b00; cs_b = 2'b11; gate_en = 1'b0;
    din = 28'h00ABCDE; par_in = 1'b1;
    @(posedge clk);
    #1;
    check("R6 pre-reset err_n", {27'h0, err_n}, 28'h0);
    check("R2 pre-reset q", qa, 28'h00ABCDE);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1 async qa", qa, 28'h0);
    check("R1 async qb", qb, 28'h0);
    check("R1 async err_n", {27'h0, err_n}, 28'h1);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // randomised comparison against the reference model
    m_q = '0; m_eval = 1'b0; m_p1 = 1'b0; m_err = 1'b1; m_cnt = 0;
    for (int n = 0; n < 3000; n++) begin
      cs_a    = {($urandom % 10) < 7, ($urandom % 10) < 7};
      cs_b    = {($urandom % 10) < 7, ($urandom % 10) < 7};
      gate_en = ($urandom % 4) != 0;
      din     = 28'($urandom);
      par_in  = m_p1 ^ (($urandom % 5) == 0);
      model_edge();
      @(posedge clk);
      #1;
      check("R2 R4 random q", qa, m_q);
      check("R3 random copy", qb, qa);
      check("R6 R8 R9 random err_n", {27'h0, err_n}, {27'h0, m_err});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule